// File: doc/BRIEF.md
# Fractional Audio Master and Bit Clock Generator

This block derives two audio timing signals from a fast system clock. The first is a master clock. A phase accumulator steps by a programmed numerator each cycle and wraps at a programmed denominator. Each wrap flips the master clock level, so the master clock runs at the system clock times numerator/denominator, halved. The second is a bit clock. An integer divider counts master-clock flips and flips the bit clock once every divisor-plus-one of them, so the bit clock keeps an even duty cycle.

Both signals come out as registered levels. Each also has a one-cycle strobe that is high in the cycle its level has just changed, so logic in the system clock domain can act on the edges without a second clock. A small controller watches the three settings:
- Any change sends it through a one-cycle load step that clears the accumulator, the counter and both levels.
- After the load step it enters either running or halted, depending on whether the settings are legal.
- A zero numerator, a zero denominator or a numerator above the denominator leaves it halted with every output low.

Top module: `frac_audio_clkgen`

Controller states and transitions: `ST_HALT` (idle, outputs low), `ST_LOAD` (one cycle, datapath cleared), `ST_RUN` (accumulating). Transitions are:
- CFG_CHANGE: any state to `ST_LOAD` when any setting differs from the value seen on the previous cycle.
- LOAD_OK: `ST_LOAD` to `ST_RUN` when the settings are legal.
- LOAD_BAD: `ST_LOAD` to `ST_HALT` when they are not.
- Otherwise each state holds.

## Requirements
- R1: After reset the controller is in `ST_HALT` and `mclk_o`, `mclk_stb_o`, `bclk_o`, `bclk_stb_o` and `mclk_en_o` are all 0, and they stay 0 while the settings remain zero.
- R2: When `num_i` is 0, `den_i` is 0, or `num_i` > `den_i`, the block settles in `ST_HALT`: no strobe is issued and both levels stay 0.
- R3: In each running cycle the phase grows by `num_i`. When it reaches or passes `den_i`, `den_i` is subtracted and `mclk_stb_o` is 1 after that edge. Over the first n running cycles exactly floor(n·num/den) strobes appear.
- R4: When `den_i` is an integer multiple of `num_i`, consecutive master strobes are exactly den/num cycles apart.
- R5: For any legal setting, the spacing between consecutive master strobes is always floor(den/num) or ceil(den/num) cycles.
- R6: `mclk_o` changes level exactly on the cycles where `mclk_stb_o` is 1 (apart from the clear to 0 on a settings change).
- R7: `bclk_o` flips, and `bclk_stb_o` pulses, on every (`bdiv_i`+1)-th master strobe. With `bdiv_i` = 0 it follows `mclk_o`, and a bit strobe never occurs without a master strobe.
- R8: A change of any setting causes a clear on the next two edges. Running starts on the second edge with both levels 0, and the first accumulation happens on the third edge.
- R9: `mclk_en_o` is 1 exactly while the controller is in `ST_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| num_i | input | 8 | Rate numerator (phase step) |
| den_i | input | 8 | Rate denominator (phase modulus) |
| bdiv_i | input | 6 | Bit clock divisor minus one |
| mclk_en_o | output | 1 | Master clock running |
| mclk_o | output | 1 | Master clock level |
| mclk_stb_o | output | 1 | One-cycle pulse after each master level change |
| bclk_o | output | 1 | Bit clock level |
| bclk_stb_o | output | 1 | One-cycle pulse after each bit level change |

## Verification
The assertions check the local rules on every cycle:
- a strobe only appears while running;
- each level changes only with its strobe;
- a bit strobe only comes with a master strobe;
- entry into running always starts from low levels.

Other properties need long observation, and only the bench's scenarios can show them. These are the exact strobe count over a long window, the absence of jitter for an integer ratio, the two-value spacing for a fractional ratio, the halt on each illegal setting, and the bit clock period for several divisors. A behavioural model compared on every cycle covers the exact timing of the load sequence.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_t;
endpackage

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
    import clkgen_pkg::*;
#(
    parameter int NUM_W  = 8,
    parameter int BDIV_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_W-1:0]  num_i,
    input  logic [NUM_W-1:0]  den_i,
    input  logic [BDIV_W-1:0] bdiv_i,
    output logic              clr_o,
    output logic              run_o,
    output logic              en_o
);
    localparam int CFG_W = 2*NUM_W + BDIV_W;

    gen_state_t state_q, state_d;
    logic [CFG_W-1:0] cfg_now, cfg_q;
    logic cfg_change, cfg_legal;

    assign cfg_now    = {num_i, den_i, bdiv_i};
    assign cfg_change = (cfg_now != cfg_q);
    assign cfg_legal  = (num_i != '0) && (den_i != '0) && (num_i <= den_i);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            cfg_q   <= cfg_now;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cfg_change) begin
            state_d = ST_LOAD;
        end else begin
            unique case (state_q)
                ST_HALT: state_d = ST_HALT;
                ST_LOAD: state_d = cfg_legal ? ST_RUN : ST_HALT;
                ST_RUN:  state_d = ST_RUN;
                default: state_d = ST_HALT;
            endcase
        end
    end

    // outputs
    always_comb begin
        clr_o = cfg_change;
        run_o = 1'b0;
        en_o  = 1'b0;
        unique case (state_q)
            ST_HALT: ;
            ST_LOAD: clr_o = 1'b1;
            ST_RUN: begin
                en_o  = 1'b1;
                run_o = !cfg_change;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/clkgen_frac_acc.sv
module clkgen_frac_acc #(
    parameter int NUM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             run_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [NUM_W-1:0] den_i,
    output logic             hit_o,
    output logic             lvl_o,
    output logic             stb_o
);
    localparam int ACC_W = NUM_W + 1;

    logic [ACC_W-1:0] phase_q, phase_sum, den_ext;

    assign den_ext   = {1'b0, den_i};
    assign phase_sum = phase_q + {1'b0, num_i};
    assign hit_o     = run_i && (phase_sum >= den_ext);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            lvl_o   <= 1'b0;
            stb_o   <= 1'b0;
        end else if (clr_i) begin
            phase_q <= '0;
            lvl_o   <= 1'b0;
            stb_o   <= 1'b0;
        end else begin
            stb_o <= hit_o;
            if (run_i) begin
                phase_q <= hit_o ? (phase_sum - den_ext) : phase_sum;
            end
            if (hit_o) begin
                lvl_o <= !lvl_o;
            end
        end
    end
endmodule

// File: rtl/clkgen_bit_div.sv
module clkgen_bit_div #(
    parameter int BDIV_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              hit_i,
    input  logic [BDIV_W-1:0] bdiv_i,
    output logic              lvl_o,
    output logic              stb_o
);
    logic [BDIV_W-1:0] cnt_q;
    logic              wrap;

    assign wrap = hit_i && (cnt_q == bdiv_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_o <= 1'b0;
            stb_o <= 1'b0;
        end else if (clr_i) begin
            cnt_q <= '0;
            lvl_o <= 1'b0;
            stb_o <= 1'b0;
        end else begin
            stb_o <= wrap;
            if (wrap) begin
                cnt_q <= '0;
                lvl_o <= !lvl_o;
            end else if (hit_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/frac_audio_clkgen.sv
module frac_audio_clkgen #(
    parameter int NUM_W  = 8,
    parameter int BDIV_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_W-1:0]  num_i,
    input  logic [NUM_W-1:0]  den_i,
    input  logic [BDIV_W-1:0] bdiv_i,
    output logic              mclk_en_o,
    output logic              mclk_o,
    output logic              mclk_stb_o,
    output logic              bclk_o,
    output logic              bclk_stb_o
);
    logic clr, run, hit;

    clkgen_ctrl #(.NUM_W(NUM_W), .BDIV_W(BDIV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .num_i(num_i), .den_i(den_i), .bdiv_i(bdiv_i),
        .clr_o(clr), .run_o(run), .en_o(mclk_en_o)
    );

    clkgen_frac_acc #(.NUM_W(NUM_W)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .clr_i(clr), .run_i(run),
        .num_i(num_i), .den_i(den_i),
        .hit_o(hit), .lvl_o(mclk_o), .stb_o(mclk_stb_o)
    );

    clkgen_bit_div #(.BDIV_W(BDIV_W)) u_bdiv (
        .clk(clk), .rst_n(rst_n),
        .clr_i(clr), .hit_i(hit), .bdiv_i(bdiv_i),
        .lvl_o(bclk_o), .stb_o(bclk_stb_o)
    );
endmodule

// File: rtl/clkgen_checker.sv
module clkgen_checker (
    input logic clk,
    input logic rst_n,
    input logic mclk_en_o,
    input logic mclk_o,
    input logic mclk_stb_o,
    input logic bclk_o,
    input logic bclk_stb_o
);
    // R2, R9: strobes only while running
    a_r2_stb_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_stb_o |-> mclk_en_o);

    // R6: master level flips with its strobe
    a_r6_flip_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_stb_o |-> (mclk_o != $past(mclk_o)));

    // R6: master level holds between strobes while running
    a_r6_hold_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_en_o && !mclk_stb_o) |-> $stable(mclk_o));

    // R7: bit strobe needs a master strobe
    a_r7_bstb_with_mstb: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_stb_o |-> mclk_stb_o);

    // R7: bit level flips with its strobe
    a_r7_bflip_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
        bclk_stb_o |-> (bclk_o != $past(bclk_o)));

    // R7: bit level holds between strobes while running
    a_r7_bhold_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk_en_o && $past(mclk_en_o) && !bclk_stb_o) |-> $stable(bclk_o));

    // R8: running starts from low levels
    a_r8_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mclk_en_o) |-> (!mclk_o && !bclk_o && !mclk_stb_o));
endmodule

bind frac_audio_clkgen clkgen_checker u_checker (
    .clk(clk), .rst_n(rst_n), .mclk_en_o(mclk_en_o), .mclk_o(mclk_o),
    .mclk_stb_o(mclk_stb_o), .bclk_o(bclk_o), .bclk_stb_o(bclk_stb_o)
);

// File: tb/frac_audio_clkgen_bench.sv
module frac_audio_clkgen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] num = '0;
    logic [7:0] den = '0;
    logic [5:0] bdiv = '0;
    logic mclk_en, mclk, mclk_stb, bclk, bclk_stb;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    frac_audio_clkgen u_frac_audio_clkgen (
        .clk(clk), .rst_n(rst_n), .num_i(num), .den_i(den), .bdiv_i(bdiv),
        .mclk_en_o(mclk_en), .mclk_o(mclk), .mclk_stb_o(mclk_stb),
        .bclk_o(bclk), .bclk_stb_o(bclk_stb)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced at every rising edge
    int m_st = 0;           // 0 halt, 1 load, 2 run
    int m_phase = 0, m_cnt = 0;
    int p_num = 0, p_den = 0, p_bdiv = 0;
    bit m_mclk = 0, m_mstb = 0, m_bclk = 0, m_bstb = 0, m_en = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_phase = 0; m_cnt = 0;
            p_num = 0; p_den = 0; p_bdiv = 0;
            m_mclk = 0; m_mstb = 0; m_bclk = 0; m_bstb = 0; m_en = 0;
        end else begin
            bit changed, legal, going;
            changed = (int'(num) != p_num) || (int'(den) != p_den) || (int'(bdiv) != p_bdiv);
            legal   = (num != 0) && (den != 0) && (num <= den);
            going   = (m_st == 2) && !changed;
            m_mstb = 0; m_bstb = 0;
            if (changed || m_st == 1) begin
                m_phase = 0; m_cnt = 0; m_mclk = 0; m_bclk = 0;
            end else if (going) begin
                m_phase += int'(num);
                if (m_phase >= int'(den)) begin
                    m_phase -= int'(den);
                    m_mstb = 1;
                    m_mclk = !m_mclk;
                    if (m_cnt == int'(bdiv)) begin
                        m_cnt = 0; m_bclk = !m_bclk; m_bstb = 1;
                    end else m_cnt++;
                end
            end
            if (changed) m_st = 1;
            else if (m_st == 1) m_st = legal ? 2 : 0;
            m_en = (m_st == 2);
            p_num = int'(num); p_den = int'(den); p_bdiv = int'(bdiv);
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(mclk_en == m_en, "R9 mclk_en_o vs model", mclk_en, m_en);
            chk(mclk_stb == m_mstb, "R3 mclk_stb_o vs model", mclk_stb, m_mstb);
            chk(mclk == m_mclk, "R6 mclk_o vs model", mclk, m_mclk);
            chk(bclk == m_bclk && bclk_stb == m_bstb, "R7 bclk vs model",
                {bclk, bclk_stb}, {m_bclk, m_bstb});
        end
    end

    // apply settings, then stop at the negedge just before the first accumulation
    task automatic setup(input int x, input int y, input int b);
        @(negedge clk);
        num = 8'(x); den = 8'(y); bdiv = 6'(b);
        @(negedge clk);
        chk(mclk_en == 0, "R8 load step not running", mclk_en, 0);
        @(negedge clk);
    endtask

    task automatic observe(input int n, output int mc, output int bc,
                           output int gmin, output int gmax, output int bgap);
        int last = -1, blast = -1;
        mc = 0; bc = 0; gmin = 1 << 30; gmax = 0; bgap = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mclk_stb) begin
                if (last >= 0) begin
                    if (i - last < gmin) gmin = i - last;
                    if (i - last > gmax) gmax = i - last;
                end
                last = i; mc++;
            end
            if (bclk_stb) begin
                if (blast >= 0) bgap = i - blast;
                blast = i; bc++;
            end
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int mc, bc, gmin, gmax, bgap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk({mclk_en, mclk, mclk_stb, bclk, bclk_stb} == 5'b0, "R1 reset outputs",
            {mclk_en, mclk, mclk_stb, bclk, bclk_stb}, 0);
        observe(50, mc, bc, gmin, gmax, bgap);
        chk(mc == 0 && mclk_en == 0, "R1 halted until programmed", mc, 0);

        // R3, R5: 7/17 over a long window
        setup(7, 17, 0);
        chk(mclk_en == 1 && mclk == 0 && bclk == 0, "R8 run entry low",
            {mclk_en, mclk, bclk}, 3'b100);
        observe(1700, mc, bc, gmin, gmax, bgap);
        chk(mc == 700, "R3 strobe count 7/17 over 1700", mc, 700);
        chk(gmin == 2, "R5 min spacing 7/17", gmin, 2);
        chk(gmax == 3, "R5 max spacing 7/17", gmax, 3);

        // R4: integer ratio 2/6
        setup(2, 6, 0);
        observe(600, mc, bc, gmin, gmax, bgap);
        chk(mc == 200, "R4 strobe count 2/6", mc, 200);
        chk(gmin == 3 && gmax == 3, "R4 no jitter 2/6", gmax, 3);

        // R3: full rate x == y
        setup(5, 5, 0);
        observe(40, mc, bc, gmin, gmax, bgap);
        chk(mc == 40, "R3 num equals den strobes every cycle", mc, 40);

        // R2: illegal settings
        setup(0, 9, 0);
        observe(200, mc, bc, gmin, gmax, bgap);
        chk(mc == 0 && mclk_en == 0 && mclk == 0, "R2 zero numerator halted", mc, 0);
        setup(9, 0, 0);
        observe(200, mc, bc, gmin, gmax, bgap);
        chk(mc == 0 && mclk_en == 0 && mclk == 0, "R2 zero denominator halted", mc, 0);
        setup(10, 9, 0);
        observe(200, mc, bc, gmin, gmax, bgap);
        chk(mc == 0 && mclk_en == 0 && bclk == 0, "R2 num above den halted", mc, 0);

        // R7: bit clock divisors with 1/2 (strobe every 2 cycles)
        setup(1, 2, 0);
        observe(400, mc, bc, gmin, gmax, bgap);
        chk(bc == mc && bgap == 2, "R7 divisor 0 follows master", bgap, 2);
        setup(1, 2, 3);
        observe(400, mc, bc, gmin, gmax, bgap);
        chk(bgap == 8 && bc == 50, "R7 divisor 3 spacing", bgap, 8);
        setup(1, 2, 63);
        observe(1400, mc, bc, gmin, gmax, bgap);
        chk(bgap == 128 && bc == 10, "R7 divisor 63 spacing", bgap, 128);

        // R8: change while running with high levels
        setup(1, 1, 0);
        @(negedge clk);
        chk(mclk == 1 && bclk == 1, "R8 levels high before change", mclk, 1);
        num = 8'd1; den = 8'd3;
        @(negedge clk);
        chk(mclk == 0 && bclk == 0 && mclk_en == 0, "R8 change clears levels",
            {mclk, bclk, mclk_en}, 0);
        @(negedge clk);
        chk(mclk_en == 1 && mclk == 0, "R8 running resumes low", {mclk_en, mclk}, 2);
        observe(3, mc, bc, gmin, gmax, bgap);
        chk(mc == 1 && mclk == 1, "R8 first strobe after third run cycle", mc, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule